// File: doc/BRIEF.md
# Power Control Register with Overdrive Switch Sequencing

This block is the main control register of a small power controller. Software reaches it over a simple register bus with a single-cycle write strobe, per-byte write enables and a read that returns data in the same cycle. The register holds the voltage scaling field, the low-power mode selects, the under-drive selection, two flash-stop controls, and the overdrive enable and overdrive switch controls. Its live contents are also driven out on a parallel port to the rest of the power controller.

The overdrive switch bit is not a plain storage bit. A write that sets it is accepted only when the regulator reports overdrive ready. Any write to it is accepted only while an on-chip or external oscillator drives the system clock and no earlier switch is still settling. Hardware clears the bit on an exit from stop mode and whenever overdrive enable ends up cleared. Every change of the switch bit, in either direction, raises a clock-stall request. That request holds until the regulator reports that the voltage has settled.

The two flag-clear command bits always read as zero. Writing a one to either of them produces a single-cycle clear pulse for the matching status flag. A wakeup from standby reloads the register exactly as a reset does.

Top module: `pwr_ctrl_regbank`

## Requirements
- R1: After `rst` or a cycle with `standby_wake` high, `cfg` equals 0x0000C000 (voltage scaling field bits 15:14 = 11), `clk_stall` is low and both clear pulses are low.
- R2: Bits 31:22 and bit 12 always read as zero, and writes to them are ignored. A write to any offset other than `ADDR_OFF` changes nothing, and a read of such an offset returns zero.
- R3: A write changes only the bytes whose `wstrb` bit is set (bit n covers data bits 8n+7:8n). The ordinary bits 16, 15:13, 11:4 and 1:0 take the written value in the next cycle.
- R4: The under-drive field (bits 19:18) accepts the codes 00 and 11. A write of 01 or 10 leaves the field unchanged.
- R5: While `flash_exec` is high, a write cannot move flash-stop bit 21 or bit 20 from 0 to 1. Clearing them is always accepted.
- R6: A write of 1 to the switch bit (bit 17) sets it only if `od_ready` is high in the write cycle. Otherwise the bit keeps its value.
- R7: Writes to bit 17, setting or clearing, are ignored unless `osc_sysclk` is high and `clk_stall` is low in the write cycle.
- R8: Bit 17 is cleared by hardware in the cycle after `stop_exit` is high, and whenever the written or held overdrive enable (bit 16) is 0.
- R9: When bit 17 changes value, `clk_stall` is high in the same cycle as the new value. It stays high until `settle_done` is sampled high, and it is low in the following cycle.
- R10: Bits 3 and 2 read as zero. A write of 1 to bit 3 or bit 2 with byte 0 enabled gives a one-cycle high on `clr_standby_flag` or `clr_wakeup_flag`, respectively, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_wake | input | 1 | Wakeup from standby; reloads the reset value |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte write enables |
| rdata | output | 32 | Zero-wait read data for `addr` |
| osc_sysclk | input | 1 | High while an oscillator, not a PLL, is the system clock |
| od_ready | input | 1 | Regulator overdrive ready |
| stop_exit | input | 1 | One-cycle pulse on exit from stop mode |
| settle_done | input | 1 | Regulator voltage setup finished |
| flash_exec | input | 1 | Code is currently executing from flash |
| cfg | output | 32 | Current register contents |
| clk_stall | output | 1 | Request to stall the system clock |
| clr_standby_flag | output | 1 | Clear pulse for the standby status flag |
| clr_wakeup_flag | output | 1 | Clear pulse for the wakeup status flag |

## Verification
The overdrive switch is tried with each gating input withheld in turn: ready low, a PLL clock source, and a write during a stall. This separates a missing ready gate from a missing clock-source or stall gate. The hardware clears are driven from two causes, a cleared enable and a stop exit, so both paths are seen to start a stall. A settle pulse is then used to show release on the following cycle. Byte-enable, reserved-code and flash-execution patterns each leave one field unchanged while the others move. A long stretch of random inputs is finally compared against the cycle model to catch ordering interactions between the hardware clears, the stall and the bus writes.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;
  localparam int CR_W   = 32;
  localparam int NBYTES = CR_W / 8;

  localparam logic [CR_W-1:0] CR_RST = 32'h0000_C000;

  localparam int B_FIS  = 21;
  localparam int B_FMS  = 20;
  localparam int B_UDHI = 19;
  localparam int B_UDLO = 18;
  localparam int B_ODSW = 17;
  localparam int B_ODEN = 16;
  localparam int B_CSB  = 3;
  localparam int B_CWU  = 2;

  // ordinary read/write bits: 16, 15:13, 11:4, 1:0
  localparam logic [CR_W-1:0] PLAIN_MASK = 32'h0001_EFF3;
  localparam logic [CR_W-1:0] ODSW_MASK  = 32'h0002_0000;
endpackage

// File: rtl/pwr_cr_merge.sv
module pwr_cr_merge
  import pwr_ctrl_pkg::*;
(
  input  logic [CR_W-1:0]   cur,
  input  logic [CR_W-1:0]   wdata,
  input  logic [NBYTES-1:0] wstrb,
  input  logic              hit,
  input  logic              flash_exec,
  output logic [CR_W-1:0]   nxt,
  output logic              sw_wr,
  output logic              csb_req,
  output logic              cwu_req
);
  logic [CR_W-1:0] bmask;
  logic [CR_W-1:0] en;
  logic [1:0]      ud_code;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign bmask[8*b +: 8] = {8{wstrb[b]}};
  end

  assign en      = hit ? bmask : '0;
  assign ud_code = wdata[B_UDHI:B_UDLO];

  always_comb begin
    nxt = (cur & ~(en & PLAIN_MASK)) | (wdata & en & PLAIN_MASK);
    if (en[B_UDLO] && (ud_code == 2'b00 || ud_code == 2'b11))
      nxt[B_UDHI:B_UDLO] = ud_code;
    if (en[B_FIS])
      nxt[B_FIS] = wdata[B_FIS] & (cur[B_FIS] | ~flash_exec);
    if (en[B_FMS])
      nxt[B_FMS] = wdata[B_FMS] & (cur[B_FMS] | ~flash_exec);
  end

  assign sw_wr   = en[B_ODSW];
  assign csb_req = en[B_CSB] & wdata[B_CSB];
  assign cwu_req = en[B_CWU] & wdata[B_CWU];
endmodule

// File: rtl/pwr_od_seq.sv
module pwr_od_seq (
  input  logic clk,
  input  logic srst,
  input  logic sw_wr,
  input  logic sw_wbit,
  input  logic od_en_nxt,
  input  logic od_ready,
  input  logic osc_sysclk,
  input  logic stop_exit,
  input  logic settle_done,
  output logic sw_q,
  output logic stall_q
);
  logic sw_nxt;

  always_comb begin
    sw_nxt = sw_q;
    if (sw_wr && osc_sysclk && !stall_q)
      sw_nxt = sw_wbit ? (sw_q | od_ready) : 1'b0;
    if (stop_exit || !od_en_nxt)
      sw_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      sw_q    <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      sw_q    <= sw_nxt;
      stall_q <= (stall_q & ~settle_done) | (sw_nxt ^ sw_q);
    end
  end

  // R6
  sw_set_ready_chk: assert property (@(posedge clk) disable iff (srst)
    (!$past(srst) && $rose(sw_q)) |-> $past(od_ready && osc_sysclk));

  // R8
  stop_exit_clr_chk: assert property (@(posedge clk) disable iff (srst)
    stop_exit |=> !sw_q);

  // R9
  change_stall_chk: assert property (@(posedge clk) disable iff (srst)
    (!$past(srst) && (sw_q != $past(sw_q))) |-> stall_q);

  // R9
  stall_release_chk: assert property (@(posedge clk) disable iff (srst)
    (stall_q && settle_done) |=> (!stall_q || (sw_q != $past(sw_q))));
endmodule

// File: rtl/pwr_ctrl_regbank.sv
module pwr_ctrl_regbank
  import pwr_ctrl_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ADDR_OFF = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby_wake,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CR_W-1:0]   wdata,
  input  logic [NBYTES-1:0] wstrb,
  output logic [CR_W-1:0]   rdata,
  input  logic              osc_sysclk,
  input  logic              od_ready,
  input  logic              stop_exit,
  input  logic              settle_done,
  input  logic              flash_exec,
  output logic [CR_W-1:0]   cfg,
  output logic              clk_stall,
  output logic              clr_standby_flag,
  output logic              clr_wakeup_flag
);
  logic [CR_W-1:0] cfg_q;
  logic [CR_W-1:0] merge_nxt;
  logic            srst;
  logic            sel;
  logic            hit;
  logic            sw_wr;
  logic            csb_req;
  logic            cwu_req;
  logic            sw_q;

  assign srst = rst | standby_wake;
  assign sel  = (addr == ADDR_OFF);
  assign hit  = wr_en & sel;

  assign cfg   = cfg_q | ({{(CR_W-1){1'b0}}, sw_q} << B_ODSW);
  assign rdata = sel ? cfg : '0;

  pwr_cr_merge u_merge (
    .cur        (cfg),
    .wdata      (wdata),
    .wstrb      (wstrb),
    .hit        (hit),
    .flash_exec (flash_exec),
    .nxt        (merge_nxt),
    .sw_wr      (sw_wr),
    .csb_req    (csb_req),
    .cwu_req    (cwu_req)
  );

  pwr_od_seq u_od (
    .clk         (clk),
    .srst        (srst),
    .sw_wr       (sw_wr),
    .sw_wbit     (wdata[B_ODSW]),
    .od_en_nxt   (merge_nxt[B_ODEN]),
    .od_ready    (od_ready),
    .osc_sysclk  (osc_sysclk),
    .stop_exit   (stop_exit),
    .settle_done (settle_done),
    .sw_q        (sw_q),
    .stall_q     (clk_stall)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      cfg_q            <= CR_RST;
      clr_standby_flag <= 1'b0;
      clr_wakeup_flag  <= 1'b0;
    end else begin
      cfg_q            <= merge_nxt & ~ODSW_MASK;
      clr_standby_flag <= csb_req;
      clr_wakeup_flag  <= cwu_req;
    end
  end

  // R1
  wake_reload_chk: assert property (@(posedge clk) disable iff (rst)
    $past(standby_wake) |-> (cfg == CR_RST && !clk_stall));

  // R4
  ud_code_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg[B_UDHI:B_UDLO] != 2'b01) && (cfg[B_UDHI:B_UDLO] != 2'b10));

  // R5
  flash_set_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(cfg[B_FMS]) || $rose(cfg[B_FIS])) |-> !$past(flash_exec));

  // R10
  clr_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_standby_flag || clr_wakeup_flag) |-> $past(wr_en && wstrb[0] && !standby_wake));
endmodule

// File: tb/sim_pwr_ctrl_regbank.sv
module sim_pwr_ctrl_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        standby_wake = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic [31:0] rdata;
  logic        osc_sysclk = 1'b1;
  logic        od_ready = 1'b0;
  logic        stop_exit = 1'b0;
  logic        settle_done = 1'b0;
  logic        flash_exec = 1'b0;
  logic [31:0] cfg;
  logic        clk_stall;
  logic        clr_standby_flag;
  logic        clr_wakeup_flag;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string phase = "R1";

  // behavioural model state
  logic [31:0] m_reg = 32'h0000_C000;
  logic        m_st = 1'b0;
  logic        m_sb = 1'b0;
  logic        m_wu = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_ctrl_regbank u0 (
    .clk(clk), .rst(rst), .standby_wake(standby_wake), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .wstrb(wstrb), .rdata(rdata),
    .osc_sysclk(osc_sysclk), .od_ready(od_ready), .stop_exit(stop_exit),
    .settle_done(settle_done), .flash_exec(flash_exec), .cfg(cfg),
    .clk_stall(clk_stall), .clr_standby_flag(clr_standby_flag),
    .clr_wakeup_flag(clr_wakeup_flag)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_next();
    logic [31:0] n;
    bit          hit;
    n = m_reg;
    if (rst || standby_wake) begin
      m_reg = 32'h0000_C000; m_st = 0; m_sb = 0; m_wu = 0;
      return;
    end
    hit = wr_en && (addr == 8'h00);
    m_sb = hit && wstrb[0] && wdata[3];
    m_wu = hit && wstrb[0] && wdata[2];
    if (hit) begin
      for (int i = 0; i < 24; i++) begin
        if (wstrb[i/8]) begin
          if (i == 0 || i == 1 || (i >= 4 && i <= 11) || (i >= 13 && i <= 16))
            n[i] = wdata[i];
          else if (i == 20 || i == 21) begin
            if (!(wdata[i] && !m_reg[i] && flash_exec)) n[i] = wdata[i];
          end else if (i == 17) begin
            if (osc_sysclk && !m_st) begin
              if (wdata[17] && od_ready) n[17] = 1'b1;
              else if (!wdata[17]) n[17] = 1'b0;
            end
          end
        end
      end
      if (wstrb[2] && (wdata[19:18] == 2'b00 || wdata[19:18] == 2'b11))
        n[19:18] = wdata[19:18];
    end
    if (stop_exit || !n[16]) n[17] = 1'b0;
    m_st  = (m_st && !settle_done) || (n[17] != m_reg[17]);
    m_reg = n;
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    wr_en = w; addr = a; wdata = d; wstrb = s;
    model_next();
    @(posedge clk);
    @(negedge clk);
    check({phase, " cfg"}, cfg, m_reg);
    check({phase, " ctl"}, {29'd0, clk_stall, clr_standby_flag, clr_wakeup_flag},
          {29'd0, m_st, m_sb, m_wu});
    check({phase, " rdata"}, rdata, (a == 8'h00) ? m_reg : 32'h0);
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 32'h0, 4'h0);
  endtask

  initial begin
    @(negedge clk);
    rst = 1'b1;
    repeat (3) idle();
    rst = 1'b0;
    idle();
    // R1 reset value
    check("R1 reset cfg", cfg, 32'h0000_C000);
    check("R1 reset stall", {31'd0, clk_stall}, 32'd0);

    phase = "R2";
    step(1'b1, 8'h00, 32'hFFFF_FFFF, 4'hF);
    check("R2 reserved bits", cfg, 32'h003D_EFF3);
    // R10 pulse next cycle
    check("R10 clear pulses", {30'd0, clr_standby_flag, clr_wakeup_flag}, 32'd3);
    check("R10 read zero", {30'd0, rdata[3:2]}, 32'd0);
    idle();
    check("R10 pulse single", {30'd0, clr_standby_flag, clr_wakeup_flag}, 32'd0);
    step(1'b1, 8'h04, 32'h0000_0000, 4'hF);
    check("R2 other offset cfg", cfg, 32'h003D_EFF3);
    check("R2 other offset rdata", rdata, 32'h0);

    phase = "R3";
    step(1'b1, 8'h00, 32'h0000_0000, 4'b0001);
    check("R3 byte0 only", cfg, 32'h003D_EF00);

    phase = "R4";
    step(1'b1, 8'h00, 32'h0004_0000, 4'b0100);
    check("R4 code 01 kept", cfg, 32'h000C_EF00);
    step(1'b1, 8'h00, 32'h0000_0000, 4'b0100);
    check("R4 code 00", cfg, 32'h0000_EF00);
    step(1'b1, 8'h00, 32'h0008_0000, 4'b0100);
    check("R4 code 10 kept", cfg, 32'h0000_EF00);
    step(1'b1, 8'h00, 32'h000C_0000, 4'b0100);
    check("R4 code 11", cfg, 32'h000C_EF00);

    phase = "R5";
    flash_exec = 1'b1;
    step(1'b1, 8'h00, 32'h003C_0000, 4'b0100);
    check("R5 set rejected", cfg, 32'h000C_EF00);
    flash_exec = 1'b0;
    step(1'b1, 8'h00, 32'h003C_0000, 4'b0100);
    check("R5 set accepted", cfg, 32'h003C_EF00);
    flash_exec = 1'b1;
    step(1'b1, 8'h00, 32'h000C_0000, 4'b0100);
    check("R5 clear accepted", cfg, 32'h000C_EF00);
    flash_exec = 1'b0;

    phase = "R6";
    step(1'b1, 8'h00, 32'h000D_0000, 4'b0100);
    od_ready = 1'b0;
    step(1'b1, 8'h00, 32'h000F_0000, 4'b0100);
    check("R6 not ready", cfg, 32'h000D_EF00);
    check("R6 no stall", {31'd0, clk_stall}, 32'd0);

    phase = "R7";
    od_ready = 1'b1; osc_sysclk = 1'b0;
    step(1'b1, 8'h00, 32'h000F_0000, 4'b0100);
    check("R7 pll source", cfg, 32'h000D_EF00);
    osc_sysclk = 1'b1;

    phase = "R9";
    step(1'b1, 8'h00, 32'h000F_0000, 4'b0100);
    check("R9 switch on", cfg, 32'h000F_EF00);
    check("R9 stall raised", {31'd0, clk_stall}, 32'd1);
    idle(); idle();
    check("R9 stall held", {31'd0, clk_stall}, 32'd1);
    step(1'b1, 8'h00, 32'h000D_0000, 4'b0100);
    check("R7 write in stall", cfg, 32'h000F_EF00);
    settle_done = 1'b1; idle(); settle_done = 1'b0;
    check("R9 stall released", {31'd0, clk_stall}, 32'd0);

    phase = "R8";
    step(1'b1, 8'h00, 32'h000C_0000, 4'b0100);
    check("R8 enable cleared", cfg, 32'h000C_EF00);
    check("R8 stall on leave", {31'd0, clk_stall}, 32'd1);
    settle_done = 1'b1; idle(); settle_done = 1'b0;
    step(1'b1, 8'h00, 32'h000D_0000, 4'b0100);
    step(1'b1, 8'h00, 32'h000F_0000, 4'b0100);
    settle_done = 1'b1; idle(); settle_done = 1'b0;
    stop_exit = 1'b1; idle(); stop_exit = 1'b0;
    check("R8 stop exit", cfg, 32'h000D_EF00);
    check("R8 stop stall", {31'd0, clk_stall}, 32'd1);

    phase = "R1";
    standby_wake = 1'b1; idle(); standby_wake = 1'b0;
    check("R1 standby wake", cfg, 32'h0000_C000);
    check("R1 wake stall", {31'd0, clk_stall}, 32'd0);

    phase = "R3 R6 R7 R8 R9 mixed";
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      od_ready    = r[0];
      osc_sysclk  = r[1] | r[2];
      stop_exit   = (r[7:3] == 5'd0);
      settle_done = r[8] & r[9];
      flash_exec  = r[10];
      standby_wake = (r[19:11] == 9'd0);
      step(r[20] | r[21], (r[24:22] == 3'd0) ? 8'h08 : 8'h00,
           {$urandom} | (r[25] ? 32'h0001_0000 : 32'h0), r[31:28]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule